// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a serial port with one synchronous and three asynchronous framings, chosen by a 2-bit mode input. Mode 0 is a half-duplex shift-register link: the port drives its own shift clock on `txd` and moves 8 data bits LSB first over the bidirectional data line (`rxd_out`/`rxd_oe` when sending, `rxd_in` when receiving), one bit per 16 oscillator cycles. Mode 1 carries 10-bit frames (start 0, 8 data bits LSB first, stop 1). Modes 2 and 3 carry 11-bit frames that add a programmable ninth bit. Modes 1 and 3 run from an external `baud_tick` at 16 times the bit rate. Mode 2 derives its own tick from the oscillator, giving a bit every 32 cycles.

The data path has two separate channels that stand for the two registers behind one buffer address. A write into the transmit holding register is a valid/ready transfer: a beat moves when `tx_valid` and `tx_ready` are both high at a clock edge. `tx_ready` is high exactly when the holding register is empty, so a producer may hold `tx_valid` high for as long as it likes. Because the holding register sits in front of the shift register, a second character written during a frame goes out with no idle time between the frames. A pulse on `tx_irq` marks each move from the holding register into the shifter. The receive register is presented as `rx_valid` with `rx_data`/`rx_bit9`. These stay stable until a beat with `rx_ready` high takes them. `rx_valid` doubles as the receive interrupt. A frame that completes while the previous one is still pending is dropped, and this sets the sticky `rx_overrun` flag. A line held low for a whole frame time sets the sticky `brk_det` flag.

Top module: `qm_uart`

## Requirements
- R1: In mode 1, a written byte is sent on `txd` as start 0, the 8 data bits LSB first, then stop 1, each bit lasting 16 `baud_tick` pulses; `txd` rests at 1 between frames.
- R2: In modes 2 and 3, frames carry 11 bits: start 0, data LSB first, `tx_bit9` as the tenth bit, and stop 1. Mode 2 bits last 32 clock cycles whatever `baud_tick` does; mode 3 bits last 16 `baud_tick` pulses.
- R3: In mode 0, a written byte goes out LSB first on `rxd_out` with `rxd_oe` high, 16 clock cycles per bit. `txd` is low for the first 8 cycles of each bit and high for the last 8, and the data bit is stable at each rising edge of `txd`. Outside a transfer, `txd` is 1 and `rxd_oe` is 0.
- R4: `tx_ready` is 1 exactly when the holding register is empty; it falls on the cycle after an accepted beat when the shifter is busy. A character held at the end of a frame starts its start bit right after the previous stop bit, with no idle time.
- R5: `tx_irq` is a single-cycle pulse, one per character moved from the holding register into the shifter.
- R6: In modes 1–3 with `rx_en`=1, a falling edge on `rxd_in` is rechecked half a bit later. If the line is high again the start is dropped; otherwise 8 data bits are taken into `rx_data`. `rx_bit9` receives the stop bit in mode 1 and the ninth bit in modes 2/3, where the stop level is ignored.
- R7: With `rx_en`=0, no frame on `rxd_in` raises `rx_valid`.
- R8: In mode 0, reception begins only when `rx_en`=1, `rx_valid`=0 and the transmitter is idle. The port then clocks `txd` and samples `rxd_in` at each rising edge, LSB first, and sets `rx_bit9` to 0.
- R9: `rx_valid`, `rx_data` and `rx_bit9` hold until a cycle with `rx_ready`=1. A frame that completes while `rx_valid`=1 and `rx_ready`=0 is dropped, leaves `rx_data` unchanged, and sets `rx_overrun` until `ovr_clr` is pulsed.
- R10: In modes 1–3, `rxd_in` held low for one whole frame time sets `brk_det`. The frame time is 10 bit times in mode 1 and 11 in modes 2/3, each bit time being 16 ticks. `brk_det` stays set until `brk_clr` is pulsed.
- R11: After reset, `txd`=1, `rxd_oe`=0, `tx_ready`=1, `tx_irq`=0, `rx_valid`=0, `rx_overrun`=0 and `brk_det`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 shift register, 1 async 8-bit, 2 fixed-rate 9-bit, 3 variable 9-bit |
| baud_tick | input | 1 | 16x bit-rate strobe for modes 1 and 3 |
| tx_valid | input | 1 | Write beat offered |
| tx_ready | output | 1 | Holding register empty |
| tx_data | input | 8 | Character to send |
| tx_bit9 | input | 1 | Ninth bit for modes 2/3 |
| rx_en | input | 1 | Receive enable |
| rx_valid | output | 1 | Received character pending (receive interrupt) |
| rx_ready | input | 1 | Consumer takes the pending character |
| rx_data | output | 8 | Received character |
| rx_bit9 | output | 1 | Stop bit (mode 1) or ninth bit (modes 2/3) |
| rx_overrun | output | 1 | Sticky lost-character flag |
| ovr_clr | input | 1 | Clears `rx_overrun` |
| brk_det | output | 1 | Sticky break flag |
| brk_clr | input | 1 | Clears `brk_det` |
| tx_irq | output | 1 | Transmit interrupt pulse |
| txd | output | 1 | Async serial out, or shift clock in mode 0 |
| rxd_in | input | 1 | Serial data in |
| rxd_out | output | 1 | Mode 0 serial data out |
| rxd_oe | output | 1 | Mode 0 data output enable |

## Verification
Assertions check the following on every cycle: the pending receive character and its data stay put until taken, also across an overrun; the break flag stays set until cleared; a mode 0 receive only starts with nothing pending and receive enabled; the data line is never driven while the receiver owns it; the interrupt pulse lasts one cycle; and a held character loads on the exact cycle a frame ends. The bench scenarios are needed for what only the line shows: the bit order and levels of each framing, the bit lengths in oscillator cycles, the frame-to-frame spacing with no gap, the dropped false start, the ignored stop level, and the break threshold measured against a frame of zeros.

// File: rtl/qm_uart_pkg.sv
package qm_uart_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [1:0] {
    MODE_SYNC = 2'd0,
    MODE_A8   = 2'd1,
    MODE_A9F  = 2'd2,
    MODE_A9V  = 2'd3
  } umode_e;

  // bits on the line per frame (also break threshold in bit times)
  function automatic logic [3:0] line_bits(umode_e m);
    case (m)
      MODE_SYNC: return 4'(DATA_W);
      MODE_A8:   return 4'(DATA_W + 2);
      default:   return 4'(DATA_W + 3);
    endcase
  endfunction

  // bits collected by the receiver after the start bit
  function automatic logic [3:0] rx_bits(umode_e m);
    case (m)
      MODE_SYNC: return 4'(DATA_W);
      MODE_A8:   return 4'(DATA_W + 1);
      default:   return 4'(DATA_W + 2);
    endcase
  endfunction
endpackage

// File: rtl/qm_tick_gen.sv
module qm_tick_gen
  import qm_uart_pkg::*;
#(
  parameter int FDIV = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  umode_e mode,
  input  logic   baud_tick,
  output logic   tick
);
  localparam int DCW = (FDIV > 1) ? $clog2(FDIV) : 1;
  localparam logic [DCW-1:0] DLAST = DCW'(FDIV - 1);

  logic [DCW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (dcnt == DLAST) dcnt <= '0;
    else dcnt <= dcnt + 1'b1;
  end

  always_comb begin
    case (mode)
      MODE_SYNC: tick = 1'b1;
      MODE_A9F:  tick = (dcnt == DLAST);
      default:   tick = baud_tick;
    endcase
  end
endmodule

// File: rtl/qm_tx.sv
module qm_tx
  import qm_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  umode_e            mode,
  input  logic              tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_b9,
  input  logic              rx_sync_busy,
  output logic              load_irq,
  output logic              active,
  output logic              idle,
  output logic              line,
  output logic              sclk
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] TMAX  = CW'(OVS - 1);
  localparam logic [CW-1:0] THALF = CW'(OVS / 2);
  localparam int SW = DATA_W + 3;

  logic              hold_full;
  logic [DATA_W:0]   hold_q;
  logic [SW-1:0]     shreg;
  logic [3:0]        bcnt;
  logic [CW-1:0]     tcnt;
  logic              bit_end, last_bit, can_load;
  logic [SW-1:0]     frame;

  assign bit_end  = active && tick && (tcnt == TMAX);
  assign last_bit = bit_end && (bcnt == line_bits(mode) - 4'd1);
  assign can_load = hold_full &&
                    (active ? last_bit : (mode != MODE_SYNC || !rx_sync_busy));

  always_comb begin
    case (mode)
      MODE_SYNC: frame = {3'b111, hold_q[DATA_W-1:0]};
      MODE_A8:   frame = {2'b11, hold_q[DATA_W-1:0], 1'b0};
      default:   frame = {1'b1, hold_q[DATA_W], hold_q[DATA_W-1:0], 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_q    <= '0;
      shreg     <= '1;
      bcnt      <= '0;
      tcnt      <= '0;
      active    <= 1'b0;
      load_irq  <= 1'b0;
    end else begin
      load_irq <= can_load;
      if (wr_valid && !hold_full) begin
        hold_full <= 1'b1;
        hold_q    <= {wr_b9, wr_data};
      end
      if (can_load) begin
        shreg     <= frame;
        active    <= 1'b1;
        bcnt      <= '0;
        tcnt      <= '0;
        hold_full <= 1'b0;
      end else if (bit_end) begin
        tcnt <= '0;
        if (last_bit) active <= 1'b0;
        else begin
          shreg <= {1'b1, shreg[SW-1:1]};
          bcnt  <= bcnt + 4'd1;
        end
      end else if (active && tick) begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assign wr_ready = !hold_full;
  assign idle     = !active && !hold_full;
  assign line     = active ? shreg[0] : 1'b1;
  assign sclk     = (active && mode == MODE_SYNC) ? (tcnt >= THALF) : 1'b1;

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load_irq |=> !load_irq);
  p_gapfree_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (last_bit && hold_full) |=> (active && bcnt == 4'd0 && tcnt == '0));
  p_ready_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_ready);
endmodule

// File: rtl/qm_rx.sv
module qm_rx
  import qm_uart_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  umode_e            mode,
  input  logic              tick,
  input  logic              rx_en,
  input  logic              rxd,
  input  logic              tx_idle,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_b9,
  output logic              ovr,
  input  logic              ovr_clr,
  output logic              brk,
  input  logic              brk_clr,
  output logic              sync_busy,
  output logic              sclk
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] TMAX  = CW'(OVS - 1);
  localparam logic [CW-1:0] THALF = CW'(OVS / 2);
  localparam logic [CW-1:0] THM1  = CW'(OVS / 2 - 1);
  localparam int SHW = DATA_W + 2;
  localparam int LW  = $clog2((DATA_W + 3) * OVS + 1);
  localparam logic [3:0] SYNC_LAST = 4'(DATA_W - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_SYNC} rxst_e;

  rxst_e             st;
  logic [1:0]        rsync;
  logic              rxd_s;
  logic [SHW-1:0]    sh, new_sh;
  logic [3:0]        bcnt;
  logic [CW-1:0]     tcnt;
  logic [LW-1:0]     lowcnt, brk_lim;
  logic              done_a, done_s, done;
  logic [DATA_W-1:0] cdata;
  logic              cb9;

  assign rxd_s   = rsync[1];
  assign new_sh  = {rxd_s, sh[SHW-1:1]};
  assign done_a  = (st == S_DATA) && tick && (tcnt == TMAX) &&
                   (bcnt == rx_bits(mode) - 4'd1);
  assign done_s  = (st == S_SYNC) && tick && (tcnt == TMAX) && (bcnt == SYNC_LAST);
  assign done    = done_a || done_s;
  assign brk_lim = LW'(line_bits(mode)) * LW'(OVS);

  always_comb begin
    if (done_s) begin
      cdata = sh[SHW-1:2];
      cb9   = 1'b0;
    end else if (mode == MODE_A8) begin
      cdata = new_sh[DATA_W:1];
      cb9   = new_sh[DATA_W+1];
    end else begin
      cdata = new_sh[DATA_W-1:0];
      cb9   = new_sh[DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; rsync <= 2'b11; sh <= '0; bcnt <= '0; tcnt <= '0;
      rd_valid <= 1'b0; rd_data <= '0; rd_b9 <= 1'b0;
      ovr <= 1'b0; brk <= 1'b0; lowcnt <= '0;
    end else begin
      rsync <= {rsync[0], rxd};
      case (st)
        S_IDLE: begin
          tcnt <= '0;
          bcnt <= '0;
          if (mode == MODE_SYNC) begin
            if (rx_en && !rd_valid && tx_idle) st <= S_SYNC;
          end else if (rx_en && tick && !rxd_s) st <= S_START;
        end
        S_START: if (tick) begin
          if (tcnt == THM1) begin
            tcnt <= '0;
            st   <= rxd_s ? S_IDLE : S_DATA;
          end else tcnt <= tcnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (tcnt == TMAX) begin
            tcnt <= '0;
            sh   <= new_sh;
            bcnt <= bcnt + 4'd1;
            if (done_a) st <= S_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        S_SYNC: if (tick) begin
          if (tcnt == THALF) sh <= new_sh;
          if (tcnt == TMAX) begin
            tcnt <= '0;
            bcnt <= bcnt + 4'd1;
            if (done_s) st <= S_IDLE;
          end else tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase

      if (ovr_clr) ovr <= 1'b0;
      if (done) begin
        if (rd_valid && !rd_ready) ovr <= 1'b1;
        else begin
          rd_valid <= 1'b1;
          rd_data  <= cdata;
          rd_b9    <= cb9;
        end
      end else if (rd_valid && rd_ready) rd_valid <= 1'b0;

      if (mode == MODE_SYNC || rxd_s) lowcnt <= '0;
      else if (tick && lowcnt != brk_lim) lowcnt <= lowcnt + 1'b1;
      if (brk_clr) brk <= 1'b0;
      if (mode != MODE_SYNC && lowcnt == brk_lim) brk <= 1'b1;
    end
  end

  assign sync_busy = (st == S_SYNC);
  assign sclk      = (st == S_SYNC) ? (tcnt >= THALF) : 1'b1;

  p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid);
  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> ($stable(rd_data) && $stable(rd_b9)));
  p_brk_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !brk_clr) |=> brk);
  p_sync_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_busy) |-> $past(!rd_valid && rx_en));
endmodule

// File: rtl/qm_uart.sv
module qm_uart
  import qm_uart_pkg::*;
#(
  parameter int OVS  = 16,
  parameter int FDIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       baud_tick,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [7:0] tx_data,
  input  logic       tx_bit9,
  input  logic       rx_en,
  output logic       rx_valid,
  input  logic       rx_ready,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_overrun,
  input  logic       ovr_clr,
  output logic       brk_det,
  input  logic       brk_clr,
  output logic       tx_irq,
  output logic       txd,
  input  logic       rxd_in,
  output logic       rxd_out,
  output logic       rxd_oe
);
  umode_e m;
  logic   tick, tx_active, tx_idle, tx_line, tx_sclk, rx_busy, rx_sclk;

  assign m = umode_e'(mode);

  qm_tick_gen #(.FDIV(FDIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .mode(m), .baud_tick(baud_tick), .tick(tick)
  );

  qm_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .mode(m), .tick(tick),
    .wr_valid(tx_valid), .wr_ready(tx_ready), .wr_data(tx_data), .wr_b9(tx_bit9),
    .rx_sync_busy(rx_busy), .load_irq(tx_irq), .active(tx_active),
    .idle(tx_idle), .line(tx_line), .sclk(tx_sclk)
  );

  qm_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst_n(rst_n), .mode(m), .tick(tick), .rx_en(rx_en),
    .rxd(rxd_in), .tx_idle(tx_idle),
    .rd_valid(rx_valid), .rd_ready(rx_ready), .rd_data(rx_data), .rd_b9(rx_bit9),
    .ovr(rx_overrun), .ovr_clr(ovr_clr), .brk(brk_det), .brk_clr(brk_clr),
    .sync_busy(rx_busy), .sclk(rx_sclk)
  );

  assign txd     = (m == MODE_SYNC) ? (tx_sclk & rx_sclk) : tx_line;
  assign rxd_out = tx_line;
  assign rxd_oe  = tx_active && (m == MODE_SYNC);

  p_half_duplex_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rxd_oe |-> !rx_busy);
endmodule

// File: tb/qm_uart_bench.sv
module qm_uart_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       baud_tick = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] tx_data = '0;
  logic       tx_bit9 = 1'b0;
  logic       rx_en = 1'b0;
  logic       rx_valid;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit9, rx_overrun, brk_det, tx_irq, txd, rxd_out, rxd_oe;
  logic       ovr_clr = 1'b0, brk_clr = 1'b0, rxd_in = 1'b1;

  int total = 0, bad = 0, cyc = 0, irq_n = 0;
  logic bt_en = 1'b1, mon_en = 1'b0;
  int bdiv = 0;
  logic [8:0] exp_q[$];
  int starts[$];

  qm_uart u_qm_uart (
    .clk(clk), .rst_n(rst_n), .mode(mode), .baud_tick(baud_tick),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_bit9(tx_bit9),
    .rx_en(rx_en), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .rx_overrun(rx_overrun), .ovr_clr(ovr_clr),
    .brk_det(brk_det), .brk_clr(brk_clr), .tx_irq(tx_irq), .txd(txd),
    .rxd_in(rxd_in), .rxd_out(rxd_out), .rxd_oe(rxd_oe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // baud strobe: one pulse every 3 clocks -> 48 clocks per bit
  always @(negedge clk) begin
    bdiv      <= (bdiv == 2) ? 0 : bdiv + 1;
    baud_tick <= bt_en && (bdiv == 2);
  end
  always @(negedge clk) if (rst_n && tx_irq) irq_n <= irq_n + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int bitclk();
    return (mode == 2'd2) ? 32 : 48;
  endfunction

  // scoreboard monitor for asynchronous transmit frames
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && rst_n && txd == 1'b0) begin
        int bp, nb;
        logic [10:0] got;
        logic [8:0] e;
        starts.push_back(cyc);
        bp = bitclk();
        nb = (mode == 2'd1) ? 10 : 11;
        got = '1;
        repeat (bp / 2) @(negedge clk);
        got[0] = txd;
        for (int i = 1; i < nb; i++) begin
          repeat (bp) @(negedge clk);
          got[i] = txd;
        end
        if (exp_q.size() == 0) chk(1'b0, "R1", "unexpected frame", got, 0);
        else begin
          e = exp_q.pop_front();
          chk(got[0] == 1'b0, "R1", "start bit", got[0], 0);
          chk(got[8:1] == e[7:0], (nb == 10) ? "R1" : "R2", "data", got[8:1], e[7:0]);
          if (nb == 11) begin
            chk(got[9] == e[8], "R2", "ninth bit", got[9], e[8]);
            chk(got[10] == 1'b1, "R2", "stop bit", got[10], 1);
          end else chk(got[9] == 1'b1, "R1", "stop bit", got[9], 1);
        end
      end
    end
  end

  task automatic write_tx(input logic [7:0] d, input logic b9);
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1; tx_data = d; tx_bit9 = b9;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic send_tx(input logic [7:0] d, input logic b9);
    exp_q.push_back({b9, d});
    write_tx(d, b9);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (80) @(negedge clk);
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic b9, input logic stopv, input int nb);
    int bp;
    bp = bitclk();
    rxd_in = 1'b0;
    repeat (bp) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_in = d[i];
      repeat (bp) @(negedge clk);
    end
    if (nb == 11) begin
      rxd_in = b9;
      repeat (bp) @(negedge clk);
    end
    rxd_in = stopv;
    repeat (bp) @(negedge clk);
    rxd_in = 1'b1;
    repeat (bp) @(negedge clk);
  endtask

  task automatic rd_check(input logic [7:0] d, input logic b9, input string req);
    chk(rx_valid == 1'b1, req, "rx_valid", rx_valid, 1);
    chk(rx_data == d, req, "rx_data", rx_data, d);
    chk(rx_bit9 == b9, req, "rx_bit9", rx_bit9, b9);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    @(negedge clk);
    chk(rx_valid == 1'b0, "R9", "rx_valid after read", rx_valid, 0);
  endtask

  task automatic wait_txd(input logic lvl);
    while (txd != lvl) @(negedge clk);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    join_none

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(txd == 1'b1, "R11", "txd", txd, 1);
    chk(rxd_oe == 1'b0, "R11", "rxd_oe", rxd_oe, 0);
    chk(tx_ready == 1'b1, "R11", "tx_ready", tx_ready, 1);
    chk(tx_irq == 1'b0, "R11", "tx_irq", tx_irq, 0);
    chk(rx_valid == 1'b0, "R11", "rx_valid", rx_valid, 0);
    chk(rx_overrun == 1'b0 && brk_det == 1'b0, "R11", "flags", {rx_overrun, brk_det}, 0);

    // R1 mode 1 transmit, two characters
    mon_en = 1'b1; mode = 2'd1;
    send_tx(8'hA5, 1'b0);
    send_tx(8'h3C, 1'b1);
    drain();

    // R2/R4 mode 2 with baud strobe off, back-to-back
    bt_en = 1'b0; mode = 2'd2;
    starts.delete();
    send_tx(8'h96, 1'b1);
    send_tx(8'h5A, 1'b0);
    chk(tx_ready == 1'b0, "R4", "tx_ready while held", tx_ready, 0);
    drain();
    chk(starts.size() == 2, "R4", "frame count", starts.size(), 2);
    if (starts.size() == 2)
      chk((starts[1] - starts[0]) >= 350 && (starts[1] - starts[0]) <= 353,
          "R4", "start spacing (R2 32-cycle bits)", starts[1] - starts[0], 352);

    // R2 mode 3 from baud strobe
    bt_en = 1'b1; mode = 2'd3;
    starts.delete();
    send_tx(8'h3C, 1'b1);
    send_tx(8'hC3, 1'b0);
    drain();
    if (starts.size() == 2)
      chk((starts[1] - starts[0]) >= 525 && (starts[1] - starts[0]) <= 529,
          "R4", "mode 3 spacing", starts[1] - starts[0], 528);
    chk(irq_n == 6, "R5", "tx_irq pulses", irq_n, 6);

    // R3 mode 0 transmit
    mon_en = 1'b0; mode = 2'd0;
    repeat (4) @(negedge clk);
    write_tx(8'hB4, 1'b0);
    begin
      int last_rise;
      logic [7:0] got;
      last_rise = 0;
      got = '0;
      for (int i = 0; i < 8; i++) begin
        wait_txd(1'b0);
        wait_txd(1'b1);
        chk(rxd_oe == 1'b1, "R3", "rxd_oe during bit", rxd_oe, 1);
        got[i] = rxd_out;
        if (i > 0) chk(cyc - last_rise == 16, "R3", "shift clock period", cyc - last_rise, 16);
        last_rise = cyc;
      end
      chk(got == 8'hB4, "R3", "shifted byte", got, 8'hB4);
    end
    repeat (20) @(negedge clk);
    chk(rxd_oe == 1'b0 && txd == 1'b1, "R3", "idle after transfer", {rxd_oe, txd}, 1);
    chk(irq_n == 7, "R5", "tx_irq mode 0", irq_n, 7);

    // R8 mode 0 receive
    rx_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_txd(1'b0);
      rxd_in = (8'h6D >> i) & 1;
      wait_txd(1'b1);
    end
    repeat (20) @(negedge clk);
    rx_en = 1'b0;
    rxd_in = 1'b1;
    rd_check(8'h6D, 1'b0, "R8");
    repeat (40) @(negedge clk);
    chk(rx_valid == 1'b0 && txd == 1'b1, "R8", "no restart when disabled", {rx_valid, txd}, 1);

    // R6 mode 1 receive, stop into bit9
    mode = 2'd1; rx_en = 1'b1;
    repeat (10) @(negedge clk);
    rx_frame(8'hC9, 1'b0, 1'b1, 10);
    rd_check(8'hC9, 1'b1, "R6");
    // R6 mode 3 ninth bit
    mode = 2'd3;
    rx_frame(8'h17, 1'b1, 1'b1, 11);
    rd_check(8'h17, 1'b1, "R6");
    // R6 mode 2 stop level ignored
    mode = 2'd2;
    rx_frame(8'hE2, 1'b1, 1'b0, 11);
    repeat (200) @(negedge clk);
    rd_check(8'hE2, 1'b1, "R6");
    // R6 false start rejected
    rxd_in = 1'b0;
    repeat (6) @(negedge clk);
    rxd_in = 1'b1;
    repeat (400) @(negedge clk);
    chk(rx_valid == 1'b0, "R6", "glitch ignored", rx_valid, 0);

    // R7 receiver disabled
    mode = 2'd1; rx_en = 1'b0;
    rx_frame(8'h55, 1'b0, 1'b1, 10);
    chk(rx_valid == 1'b0, "R7", "disabled receive", rx_valid, 0);

    // R9 overrun
    mode = 2'd3; rx_en = 1'b1;
    rx_frame(8'h11, 1'b0, 1'b1, 11);
    rx_frame(8'h22, 1'b1, 1'b1, 11);
    chk(rx_overrun == 1'b1, "R9", "overrun set", rx_overrun, 1);
    rd_check(8'h11, 1'b0, "R9");
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    chk(rx_overrun == 1'b0, "R9", "overrun cleared", rx_overrun, 0);

    // R10 break in mode 1 (frame time 480 clocks)
    mode = 2'd1;
    repeat (10) @(negedge clk);
    rxd_in = 1'b0;
    repeat (400) @(negedge clk);
    chk(brk_det == 1'b0, "R10", "no break before frame time", brk_det, 0);
    repeat (180) @(negedge clk);
    chk(brk_det == 1'b1, "R10", "break after frame time", brk_det, 1);
    rxd_in = 1'b1;
    repeat (1100) @(negedge clk);
    chk(brk_det == 1'b1, "R10", "break sticky", brk_det, 1);
    rd_check(8'h00, 1'b0, "R10");
    ovr_clr = 1'b1; brk_clr = 1'b1; @(negedge clk);
    ovr_clr = 1'b0; brk_clr = 1'b0; @(negedge clk);
    chk(brk_det == 1'b0, "R10", "break cleared", brk_det, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule